// File: doc/BRIEF.md
# DMA Channel Enable Mask Command Registers

This block keeps two per-channel enable masks for a DMA controller: one that allows each channel to raise transfer requests, and one that allows each channel to raise error interrupts. Software never writes a mask word directly. Instead it writes a one-byte command into one of four write-only command lanes: set-request, clear-request, set-error-interrupt and clear-error-interrupt. The byte names a single channel or asks for all channels. One bus write therefore changes one mask bit with no read-modify-write, so two software agents updating different channels cannot undo each other's work.

All four command lanes share one 32-bit word at byte address 0. Byte strobes select which lanes a write carries, so a single write may issue a set and a clear against the same mask. In that case the clear takes priority. Both masks drive output ports directly. They can also be read back together from a second read-only word. Reads of the command word always return zero.

Command byte layout: bit 7 is reserved, and any byte with it set is ignored. Bit 6 selects the all-channels command. Bits 5:4 must be zero for a single-channel command. Bits 3:0 hold the channel number.

Top module: `chmask_cmd_regs`

## Requirements
- R1: After reset, both the request-enable mask and the error-interrupt-enable mask are all zeroes.
- R2: A command byte of value 0 to 15 on a set lane sets only the mask bit with that channel number. All other bits are unchanged.
- R3: A command byte of value 0 to 15 on a clear lane clears only the mask bit with that channel number. All other bits are unchanged.
- R4: A command byte of value 64 to 127 (bit 7 = 0, bit 6 = 1) sets every bit of the target mask on a set lane, or clears every bit on a clear lane. Bits 5:0 are don't-care in this case.
- R5: A command byte of value 16 to 63 (bit 7 = 0, bit 6 = 0, bits 5:4 not zero) leaves both masks unchanged.
- R6: A command byte of value 128 to 255 (bit 7 = 1) leaves both masks unchanged.
- R7: Lane placement within the command word at byte address 0:
  - byte 0 (wr_data[7:0]) is set-request;
  - byte 1 (wr_data[15:8]) is clear-request;
  - byte 2 (wr_data[23:16]) is set-error-interrupt;
  - byte 3 (wr_data[31:24]) is clear-error-interrupt.

  A lane acts only when its wr_strb bit is 1. Writes to any other address have no effect on the masks.
- R8: When one write sets and clears the same bit of a mask, that bit ends at 0.
- R9: A read of address 0 returns zero. A read of address 4 returns the request mask in rd_data[15:0] and the error-interrupt mask in rd_data[31:16]. Any other address reads zero. rd_data is combinational from rd_addr.
- R10: A command write takes effect on the clock edge at which wr_en is sampled high, and the new mask is on the outputs from that edge on. In cycles without a command write, both masks hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion is synchronised inside |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_addr | input | ADDR_W (4) | Byte address of the write |
| wr_strb | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data, one command byte per lane |
| rd_addr | input | ADDR_W (4) | Byte address of the read |
| rd_data | output | 32 | Read data, combinational |
| req_en_mask | output | NCH (16) | Request-enable mask, one bit per channel |
| err_int_mask | output | NCH (16) | Error-interrupt-enable mask, one bit per channel |

## Verification
A command write's mask result is due one rising edge after wr_en is applied. The driver therefore queues each expected mask pair just after the edge that accepts the write. The monitor compares it at the following falling edge, once the registered outputs have settled. Read data has no register in its path, so read checks are sampled a fraction of a cycle after rd_addr changes, within the same cycle. Idle cycles also queue an unchanged expectation, which checks that the masks hold between commands.

// File: rtl/chmask_pkg.sv
package chmask_pkg;
  // Command byte field positions (decoded by every command lane)
  localparam int CMD_W    = 8;
  localparam int RSV_BIT  = 7;
  localparam int GLB_BIT  = 6;
  localparam int LANES    = 4;

  // Lane order inside the command word
  typedef enum logic [1:0] {
    LANE_SET_REQ = 2'd0,
    LANE_CLR_REQ = 2'd1,
    LANE_SET_ERR = 2'd2,
    LANE_CLR_ERR = 2'd3
  } lane_e;

  // Byte addresses
  localparam int CMD_ADDR  = 0;
  localparam int MASK_ADDR = 4;
endpackage

// File: rtl/chmask_rst_sync.sv
module chmask_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/chmask_cmd_decode.sv
module chmask_cmd_decode
  import chmask_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              cmd_en,
  input  logic [CMD_W-1:0]  cmd_byte,
  output logic [NCH-1:0]    hit_vec
);
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic            rsv_top;
  logic            glb_cmd;
  logic            rsv_mid;
  logic [CH_W-1:0] ch_idx;

  always_comb begin
    rsv_top = cmd_byte[RSV_BIT];
    glb_cmd = cmd_byte[GLB_BIT];
    rsv_mid = |cmd_byte[GLB_BIT-1:CH_W];
    ch_idx  = cmd_byte[CH_W-1:0];
    hit_vec = '0;
    if (cmd_en && !rsv_top) begin
      if (glb_cmd) begin
        hit_vec = '1;
      end else if (!rsv_mid && (int'(ch_idx) < NCH)) begin
        hit_vec[ch_idx] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/chmask_mask_reg.sv
module chmask_mask_reg #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  output logic [NCH-1:0] mask_q
);
  logic [NCH-1:0] mask_d;
  logic           upd_en;

  // clear applied after set: clear has priority on a shared bit
  always_comb begin
    upd_en = (|set_vec) | (|clr_vec);
    mask_d = (mask_q | set_vec) & ~clr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (upd_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/chmask_cmd_regs.sv
module chmask_cmd_regs
  import chmask_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_strb,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NCH-1:0]    req_en_mask,
  output logic [NCH-1:0]    err_int_mask
);
  localparam int HALF = 16;

  logic                 rst_sync_n;
  logic                 cmd_hit;
  logic [LANES-1:0]     lane_en;
  logic [NCH-1:0]       lane_hit [LANES];

  chmask_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    cmd_hit = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
    lane_en = wr_strb & {LANES{cmd_hit}};
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    chmask_cmd_decode #(.NCH(NCH)) u_dec (
      .cmd_en   (lane_en[l]),
      .cmd_byte (wr_data[CMD_W*l +: CMD_W]),
      .hit_vec  (lane_hit[l])
    );
  end

  chmask_mask_reg #(.NCH(NCH)) u_req (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (lane_hit[LANE_SET_REQ]),
    .clr_vec (lane_hit[LANE_CLR_REQ]),
    .mask_q  (req_en_mask)
  );

  chmask_mask_reg #(.NCH(NCH)) u_err (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (lane_hit[LANE_SET_ERR]),
    .clr_vec (lane_hit[LANE_CLR_ERR]),
    .mask_q  (err_int_mask)
  );

  // command word reads as zero; mask word packs both masks
  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(MASK_ADDR)) begin
      rd_data[NCH-1:0]       = req_en_mask;
      rd_data[HALF +: NCH]   = err_int_mask;
    end
  end
endmodule

// File: rtl/chmask_cmd_regs_chk.sv
module chmask_cmd_regs_chk
  import chmask_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LANES-1:0]  wr_strb,
  input logic [31:0]       wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic [NCH-1:0]    req_en_mask,
  input logic [NCH-1:0]    err_int_mask
);
  logic             cmd;
  logic [LANES-1:0] lane_mid_rsv;
  logic [LANES-1:0] lane_top_rsv;
  logic [LANES-1:0] lane_chan;

  always_comb begin
    cmd = wr_en && (wr_addr == ADDR_W'(CMD_ADDR));
    for (int l = 0; l < LANES; l++) begin
      lane_top_rsv[l] = wr_data[8*l+7];
      lane_mid_rsv[l] = !wr_data[8*l+7] && !wr_data[8*l+6] && (wr_data[8*l+4 +: 2] != 2'b00);
      lane_chan[l]    = (wr_data[8*l+4 +: 4] == 4'h0);
    end
  end

  AST_SET_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && wr_strb[0] && lane_chan[0] && !wr_strb[1] |=> req_en_mask[$past(wr_data[3:0])]); // R2

  AST_CLR_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && wr_strb[1] && lane_chan[1] |=> !req_en_mask[$past(wr_data[11:8])]); // R3

  AST_CLR_ALL_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && wr_strb[3] && (wr_data[31:30] == 2'b01) |=> (err_int_mask == '0)); // R4

  AST_MID_CODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && ((lane_mid_rsv | ~wr_strb) == '1) |=> $stable(req_en_mask) && $stable(err_int_mask)); // R5

  AST_TOP_BIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd && ((lane_top_rsv | ~wr_strb) == '1) |=> $stable(req_en_mask) && $stable(err_int_mask)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd |=> $stable(req_en_mask) && $stable(err_int_mask)); // R10

  AST_CMD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == ADDR_W'(CMD_ADDR)) |-> (rd_data == '0)); // R9
endmodule

bind chmask_cmd_regs chmask_cmd_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_strb      (wr_strb),
  .wr_data      (wr_data),
  .rd_addr      (rd_addr),
  .rd_data      (rd_data),
  .req_en_mask  (req_en_mask),
  .err_int_mask (err_int_mask)
);

// File: tb/sim_chmask_cmd_regs.sv
`timescale 1ns/1ps
module sim_chmask_cmd_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [3:0]  wr_strb;
  logic [31:0] wr_data;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;
  logic [15:0] req_en_mask;
  logic [15:0] err_int_mask;

  int n_chk  = 0;
  int n_fail = 0;

  logic [15:0] exp_req = '0;
  logic [15:0] exp_err = '0;
  logic [15:0] q_req [$];
  logic [15:0] q_err [$];
  string       q_tag [$];

  always #4 clk = ~clk;   // 125 MHz

  chmask_cmd_regs u0 (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_strb (wr_strb), .wr_data (wr_data), .rd_addr (rd_addr),
    .rd_data (rd_data), .req_en_mask (req_en_mask), .err_int_mask (err_int_mask)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // reference model straight from the command encoding
  function automatic logic [15:0] bits_of(input logic [7:0] b);
    if (b >= 8'd128)     return 16'h0000;
    else if (b >= 8'd64) return 16'hFFFF;
    else if (b >= 8'd16) return 16'h0000;
    else                 return 16'h0001 << b[3:0];
  endfunction

  task automatic wr(input logic [3:0] addr, input logic [3:0] strb, input logic [31:0] data, input string tag);
    logic [15:0] s_r, c_r, s_e, c_e;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_strb = strb; wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (addr == 4'd0) begin
      s_r = strb[0] ? bits_of(data[7:0])   : '0;
      c_r = strb[1] ? bits_of(data[15:8])  : '0;
      s_e = strb[2] ? bits_of(data[23:16]) : '0;
      c_e = strb[3] ? bits_of(data[31:24]) : '0;
      exp_req = (exp_req | s_r) & ~c_r;
      exp_err = (exp_err | s_e) & ~c_e;
    end
    q_req.push_back(exp_req); q_err.push_back(exp_err); q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    @(posedge clk);
    #1;
    q_req.push_back(exp_req); q_err.push_back(exp_err); q_tag.push_back(tag);
  endtask

  task automatic rd(input logic [3:0] addr, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = addr;
    #1 check(rd_data === exp, tag, rd_data, exp);
  endtask

  // monitor: one expectation per cycle, compared at the falling edge
  always @(negedge clk) begin
    if (q_req.size() > 0) begin
      logic [15:0] er, ee;
      string t;
      er = q_req.pop_front(); ee = q_err.pop_front(); t = q_tag.pop_front();
      check({req_en_mask, err_int_mask} === {er, ee}, t,
            {req_en_mask, err_int_mask}, {er, ee});
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_strb = '0; wr_data = '0; rd_addr = 4'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({req_en_mask, err_int_mask} === 32'h0, "R1 reset masks", {req_en_mask, err_int_mask}, 32'h0);
    rd(4'd4, 32'h0, "R9 mask word after reset");

    wr(4'd0, 4'b0001, 32'h0000_0003, "R2 set req ch3");
    wr(4'd0, 4'b0001, 32'h0000_000F, "R2 set req ch15");
    wr(4'd0, 4'b0100, 32'h0000_0000, "R7 set err ch0 lane2");
    wr(4'd0, 4'b0100, 32'h0009_0000, "R2 set err ch9");
    wr(4'd0, 4'b0010, 32'h0000_0300, "R3 clear req ch3");
    wr(4'd0, 4'b1000, 32'h0900_0000, "R3 clear err ch9");
    idle("R10 hold idle");
    idle("R10 hold idle 2");

    wr(4'd0, 4'b0001, 32'h0000_0010, "R5 set 16 ignored");
    wr(4'd0, 4'b0010, 32'h0000_2500, "R5 clear 37 ignored");
    wr(4'd0, 4'b1111, 32'h3F3F_3F3F, "R5 63 on all lanes ignored");
    wr(4'd0, 4'b0010, 32'h0000_8000, "R6 clear 128 ignored");
    wr(4'd0, 4'b1010, 32'hC500_FF00, "R6 top bit ignored");
    wr(4'd0, 4'b0001, 32'h0000_008F, "R6 set 143 ignored");

    wr(4'd0, 4'b0000, 32'h4040_4040, "R7 no strobe no effect");
    wr(4'd8, 4'b1111, 32'h4040_4040, "R7 other address no effect");
    wr(4'd4, 4'b1111, 32'h4040_4040, "R7 mask word not writable");

    wr(4'd0, 4'b0001, 32'h0000_0040, "R4 global set req 64");
    wr(4'd0, 4'b0100, 32'h007F_0000, "R4 global set err 127");
    rd(4'd4, 32'hFFFF_FFFF, "R9 mask word all ones");
    wr(4'd0, 4'b0010, 32'h0000_5500, "R4 global clear req 85");
    wr(4'd0, 4'b1000, 32'h4000_0000, "R4 global clear err 64");

    wr(4'd0, 4'b0011, 32'h0000_0505, "R8 set and clear ch5");
    wr(4'd0, 4'b0011, 32'h0000_0240, "R8 global set, clear ch2");
    wr(4'd0, 4'b1100, 32'h4C0C_0000, "R8 set ch12, global clear err");
    wr(4'd0, 4'b0100, 32'h0001_0000, "R2 set err ch1");
    rd(4'd4, 32'h0002_FFFB, "R9 mask word packing");
    rd(4'd0, 32'h0, "R9 command word reads zero");
    rd(4'd12, 32'h0, "R9 unmapped reads zero");

    @(negedge clk);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule